// File: doc/BRIEF.md
# AES-256 Block Decryption Engine

This block recovers one 128-bit plaintext block from a 128-bit ciphertext block under a 256-bit key. A pulse on `start_i` samples the ciphertext and the key. The engine then runs in two phases. In the first phase it expands the key into fifteen 128-bit round keys, one per cycle, and writes each key into a fifteen-entry buffer. In the second phase it applies the inverse cipher, one round per cycle. These rounds read the stored keys from the last-generated entry down to the first.

When the last inverse round completes, the plaintext goes into an output register and `done_o` pulses for one cycle. The engine accepts a new `start_i` only while it is idle. The output register holds its value until the next operation completes. The host therefore holds no handshake state, and it may change `ct_i` and `key_i` freely once the engine has sampled them.

Top module: `aes256_dec_core`

## Requirements
- R1: While reset is applied, and after its release with no start, `done_o` is 0 and `pt_o` is all zeros.
- R2: `pt_o` equals the standard AES-256 inverse cipher of `ct_i` under `key_i`. Byte 0 of each block sits in bits [127:120] of the ciphertext and plaintext ports, and byte 0 of the key sits in bits [255:248]. For example, the key 00 01 .. 1f with ciphertext 8ea2b7ca516745bfeafc49904b496089 gives 00112233445566778899aabbccddeeff.
- R3: Key expansion produces the fifteen round keys in order 0 to 14, one per cycle. Round key k is written into buffer entry k.
- R4: Decryption reads the buffer last-first. Entry 14 is XORed into the ciphertext in the initial step, entries 13 down to 1 are used by inverse rounds 1 to 13, and entry 0 is used by the final round.
- R5: Inverse rounds 1 to 13 each apply, in this order, the inverse row shift, the inverse byte substitution, the round-key XOR and the inverse column mix (matrix rows 0e 0b 0d 09, rotated). The fourteenth round leaves out the column mix.
- R6: `done_o` goes high after the 31st rising clock edge, counting the edge that samples `start_i` as the first.
- R7: `done_o` is high for exactly one cycle per operation.
- R8: `pt_o` changes only in the cycle in which `done_o` is high. Between operations it holds its value, whatever `ct_i` and `key_i` do.
- R9: A `start_i` that arrives while the engine is expanding, decrypting or signalling done is ignored. The running operation keeps its sampled ciphertext and key, keeps its latency, and produces no extra `done_o`.
- R10: A `start_i` in the cycle directly after `done_o` begins a new operation with the full R6 latency and a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins an operation when the engine is idle |
| ct_i | input | 128 | Ciphertext block, sampled with start |
| key_i | input | 256 | Cipher key, sampled with start |
| pt_o | output | 128 | Recovered plaintext, held between operations |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume known values on `start_i` at every clock edge after reset. They also assume that the host treats `done_o`, and not any cycle count of its own, as the sign that `pt_o` is valid. The stimulus changes every input half a cycle away from the sampling edge. It raises `start_i` at points where the engine must ignore it, and at those points it also presents an altered ciphertext and key, so that a leak into the running operation changes the result. The expected plaintexts come from a forward cipher model in the bench. That model builds its substitution table from a generator walk, so it shares no structure with the engine's inverse path.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
  localparam int unsigned BLK_W = 128;
  localparam int unsigned KEY_W = 256;
  localparam int unsigned BYTES = BLK_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_EXPAND, ST_DECRYPT, ST_DONE} fsm_e;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // b^254 by square-and-multiply; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] sq;
    r  = 8'h01;
    sq = b;
    for (int i = 1; i < 8; i++) begin
      sq = gmul(sq, sq);
      r  = gmul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] fwd_sbox(input logic [7:0] b);
    logic [7:0] v;
    v = gf_inv(b);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] b);
    logic [7:0] t;
    t = rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
    return gf_inv(t);
  endfunction
endpackage

// File: rtl/aes_key_sched.sv
module aes_key_sched import aes_dec_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             step_i,
  output logic [BLK_W-1:0] rk_o
);
  localparam int unsigned HALF = KEY_W / 2;

  logic [KEY_W-1:0] win_q;
  logic [7:0]       rcon_q;
  logic             gen_even_q;
  logic [31:0]      last_w, rot_w, sub_w, temp_w;
  logic [31:0]      nw [4];
  logic [HALF-1:0]  older, newer, next_rk;

  assign older  = win_q[KEY_W-1:HALF];
  assign newer  = win_q[HALF-1:0];
  assign last_w = newer[31:0];
  assign rot_w  = gen_even_q ? {last_w[23:0], last_w[31:24]} : last_w;

  for (genvar i = 0; i < 4; i++) begin : g_subw
    assign sub_w[31-8*i -: 8] = fwd_sbox(rot_w[31-8*i -: 8]);
  end

  assign temp_w = gen_even_q ? (sub_w ^ {rcon_q, 24'h0}) : sub_w;

  // word chain of the next round key
  for (genvar j = 0; j < 4; j++) begin : g_chain
    if (j == 0) begin : g_head
      assign nw[j] = older[HALF-1 -: 32] ^ temp_w;
    end else begin : g_tail
      assign nw[j] = older[HALF-1-32*j -: 32] ^ nw[j-1];
    end
    assign next_rk[HALF-1-32*j -: 32] = nw[j];
  end

  assign rk_o = older;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '0;
      rcon_q     <= 8'h01;
      gen_even_q <= 1'b1;
    end else if (load_i) begin
      win_q      <= key_i;
      rcon_q     <= 8'h01;
      gen_even_q <= 1'b1;
    end else if (step_i) begin
      win_q      <= {newer, next_rk};
      gen_even_q <= ~gen_even_q;
      if (gen_even_q) rcon_q <= xtime(rcon_q);
    end
  end

  p_rcon_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && gen_even_q && rcon_q != 8'h80) |=> $countones(rcon_q) == 1);
  p_window_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(win_q));
endmodule

// File: rtl/aes_key_rev_buf.sv
module aes_key_rev_buf #(
  parameter int unsigned DEPTH = 15,
  parameter int unsigned WIDTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];

  p_wr_ascending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && $past(wr_en_i)) |-> wr_idx_i == $past(wr_idx_i) + 1'b1);
  p_rd_descending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && $past(rd_en_i)) |-> rd_idx_i == $past(rd_idx_i) - 1'b1);
  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));
  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> int'(wr_idx_i) < DEPTH);
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round import aes_dec_pkg::*; (
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rk_i,
  input  logic             first_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  logic [7:0] in_b  [BYTES];
  logic [7:0] shf_b [BYTES];
  logic [7:0] ark_b [BYTES];
  logic [7:0] mix_b [BYTES];
  logic [BLK_W-1:0] ark_w, mix_w;

  for (genvar n = 0; n < BYTES; n++) begin : g_byte
    assign in_b[n]  = state_i[BLK_W-1-8*n -: 8];
    assign ark_b[n] = inv_sbox(shf_b[n]) ^ rk_i[BLK_W-1-8*n -: 8];
    assign ark_w[BLK_W-1-8*n -: 8] = ark_b[n];
    assign mix_w[BLK_W-1-8*n -: 8] = mix_b[n];
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC = r + 4 * ((c + 4 - r) % 4);
      assign shf_b[r+4*c] = in_b[SRC];
    end
    assign mix_b[4*c]   = gmul(ark_b[4*c], 8'h0e) ^ gmul(ark_b[4*c+1], 8'h0b)
                        ^ gmul(ark_b[4*c+2], 8'h0d) ^ gmul(ark_b[4*c+3], 8'h09);
    assign mix_b[4*c+1] = gmul(ark_b[4*c], 8'h09) ^ gmul(ark_b[4*c+1], 8'h0e)
                        ^ gmul(ark_b[4*c+2], 8'h0b) ^ gmul(ark_b[4*c+3], 8'h0d);
    assign mix_b[4*c+2] = gmul(ark_b[4*c], 8'h0d) ^ gmul(ark_b[4*c+1], 8'h09)
                        ^ gmul(ark_b[4*c+2], 8'h0e) ^ gmul(ark_b[4*c+3], 8'h0b);
    assign mix_b[4*c+3] = gmul(ark_b[4*c], 8'h0b) ^ gmul(ark_b[4*c+1], 8'h0d)
                        ^ gmul(ark_b[4*c+2], 8'h09) ^ gmul(ark_b[4*c+3], 8'h0e);
  end

  always_comb begin
    if (first_i)     state_o = state_i ^ rk_i;
    else if (last_i) state_o = ark_w;
    else             state_o = mix_w;
  end
endmodule

// File: rtl/aes256_dec_core.sv
module aes256_dec_core import aes_dec_pkg::*; #(
  parameter int unsigned NUM_ROUNDS = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] ct_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [BLK_W-1:0] pt_o,
  output logic             done_o
);
  localparam int unsigned NUM_RK = NUM_ROUNDS + 1;
  localparam int unsigned CNT_W  = $clog2(NUM_RK);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_RK - 1);

  fsm_e             fsm_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] st_q, pt_q;
  logic [BLK_W-1:0] sched_rk, buf_rk, rnd_out;
  logic [CNT_W-1:0] rd_idx;
  logic             accept, expanding, decrypting;

  assign accept     = (fsm_q == ST_IDLE) && start_i;
  assign expanding  = (fsm_q == ST_EXPAND);
  assign decrypting = (fsm_q == ST_DECRYPT);
  assign rd_idx     = LAST_IDX - cnt_q;

  aes_key_sched u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .key_i  (key_i),
    .step_i (expanding),
    .rk_o   (sched_rk)
  );

  aes_key_rev_buf #(.DEPTH(NUM_RK), .WIDTH(BLK_W)) u_kbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (expanding),
    .wr_idx_i  (cnt_q),
    .wr_data_i (sched_rk),
    .rd_en_i   (decrypting),
    .rd_idx_i  (rd_idx),
    .rd_data_o (buf_rk)
  );

  aes_inv_round u_round (
    .state_i (st_q),
    .rk_i    (buf_rk),
    .first_i (cnt_q == '0),
    .last_i  (cnt_q == LAST_IDX),
    .state_o (rnd_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q <= ST_IDLE;
      cnt_q <= '0;
      st_q  <= '0;
      pt_q  <= '0;
    end else begin
      unique case (fsm_q)
        ST_IDLE: if (start_i) begin
          fsm_q <= ST_EXPAND;
          cnt_q <= '0;
          st_q  <= ct_i;
        end
        ST_EXPAND: if (cnt_q == LAST_IDX) begin
          fsm_q <= ST_DECRYPT;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_DECRYPT: begin
          st_q <= rnd_out;
          if (cnt_q == LAST_IDX) begin
            pt_q  <= rnd_out;
            fsm_q <= ST_DONE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: fsm_q <= ST_IDLE;
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign pt_o   = pt_q;
  assign done_o = (fsm_q == ST_DONE);

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_pt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pt_o) |-> done_o);
  p_busy_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q != ST_IDLE && start_i) |=> !(fsm_q == ST_EXPAND && cnt_q == '0));
  p_full_expand_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decrypting && $past(fsm_q) == ST_EXPAND) |-> $past(cnt_q) == LAST_IDX);
  p_first_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decrypting && cnt_q == '0) |-> rd_idx == LAST_IDX);
  p_done_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(decrypting) && $past(cnt_q) == LAST_IDX);
endmodule

// File: tb/aes256_dec_core_bench.sv
`timescale 1ns/1ps
module aes256_dec_core_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] ct_i = '0;
  logic [255:0] key_i = '0;
  logic [127:0] pt_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] sb [256];

  always #10 clk = ~clk;

  aes256_dec_core u_aes256_dec_core (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i),
    .ct_i (ct_i), .key_i (key_i), .pt_o (pt_o), .done_o (done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] v);
    return {sb[v[31:24]], sb[v[23:16]], sb[v[15:8]], sb[v[7:0]]};
  endfunction

  // table from walking powers of 3 and their inverses
  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    for (int i = 0; i < 255; i++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end
    sb[0] = 8'h63;
  endtask

  task automatic ref_encrypt(input logic [255:0] k, input logic [127:0] p, output logic [127:0] c);
    logic [31:0]  w [60];
    logic [31:0]  t;
    logic [7:0]   rc;
    logic [127:0] rk [15];
    logic [7:0]   s [16];
    logic [7:0]   u [16];
    logic [7:0]   a0, a1, a2, a3;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    rc = 8'h01;
    for (int i = 8; i < 60; i++) begin
      t = w[i-1];
      if (i % 8 == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = xt(rc);
      end else if (i % 8 == 4) begin
        t = subw(t);
      end
      w[i] = w[i-8] ^ t;
    end
    for (int r = 0; r < 15; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    for (int n = 0; n < 16; n++) s[n] = p[127-8*n -: 8] ^ rk[0][127-8*n -: 8];
    for (int r = 1; r < 15; r++) begin
      for (int n = 0; n < 16; n++) u[n] = sb[s[n]];
      for (int col = 0; col < 4; col++)
        for (int row = 0; row < 4; row++)
          s[row+4*col] = u[row+4*((col+row)%4)];
      if (r < 14) begin
        for (int col = 0; col < 4; col++) begin
          a0 = s[4*col]; a1 = s[4*col+1]; a2 = s[4*col+2]; a3 = s[4*col+3];
          s[4*col]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          s[4*col+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          s[4*col+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          s[4*col+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int n = 0; n < 16; n++) s[n] = s[n] ^ rk[r][127-8*n -: 8];
    end
    for (int n = 0; n < 16; n++) c[127-8*n -: 8] = s[n];
  endtask

  // returns at the falling edge on which done_o is first seen
  task automatic run_op(input logic [255:0] k, input logic [127:0] c, input bit poke,
                        output logic [127:0] p, output int lat);
    @(negedge clk);
    start_i = 1'b1; key_i = k; ct_i = c;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_o) break;
      start_i = poke && (lat == 3 || lat == 20);
      if (start_i) begin ct_i = ~c; key_i = ~k; end
    end
    start_i = 1'b0;
    p = pt_o;
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 128'h0, 128'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] k;
    logic [127:0] p, c, got, held;
    int lat, seen;
    build_sbox();
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && pt_o == '0, "R1 in reset", {127'h0, done_o} | pt_o, '0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && pt_o == '0, "R1 after reset", {127'h0, done_o} | pt_o, '0);

    // known vector
    k = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    run_op(k, 128'h8ea2b7ca516745bfeafc49904b496089, 1'b0, got, lat);
    chk(got == 128'h00112233445566778899aabbccddeeff, "R2 known vector", got,
        128'h00112233445566778899aabbccddeeff);
    chk(lat == 30, "R6 latency", 128'(lat), 128'd30);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 single pulse", {127'h0, done_o}, '0);

    // sweep: pattern keys and blocks, then random ones; each run starts right after done
    for (int i = 0; i < 40; i++) begin
      case (i)
        0: begin k = '0; p = '0; end
        1: begin k = '1; p = '1; end
        2: begin k = '0; p = 128'h1; end
        3: begin k = 256'h1; p = '0; end
        default: begin k = rnd256(); p = 128'(rnd256()); end
      endcase
      ref_encrypt(k, p, c);
      run_op(k, c, 1'b0, got, lat);
      chk(got == p, "R3 R4 R5 round trip", got, p);
      chk(lat == 30, "R10 back-to-back latency", 128'(lat), 128'd30);
    end

    // start pulses during expansion and decryption with altered inputs
    k = rnd256(); p = 128'(rnd256());
    ref_encrypt(k, p, c);
    run_op(k, c, 1'b1, got, lat);
    chk(got == p, "R9 busy start ignored", got, p);
    chk(lat == 30, "R9 latency kept", 128'(lat), 128'd30);

    // start during the done cycle must not begin a new operation
    held = pt_o;
    start_i = 1'b1; ct_i = ~c; key_i = ~k;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (done_o) seen++;
      ct_i = 128'(rnd256()); key_i = rnd256();
    end
    chk(seen == 0, "R9 start in done ignored", 128'(seen), 128'd0);
    chk(pt_o == held, "R8 output held", pt_o, held);

    // output unaffected by a new input while idle
    run_op(k, c, 1'b0, got, lat);
    chk(got == p, "R2 after idle", got, p);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      ct_i = 128'(rnd256()); key_i = rnd256();
    end
    chk(pt_o == p, "R8 stable between ops", pt_o, p);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule